// File: doc/BRIEF.md
# Directory Home Controller

This block is the home-node directory engine for a group of memory blocks in a shared-memory machine built from `NODES` nodes. For every block it tracks whether the block is uncached, held read-only by a set of nodes, or held writable by exactly one node. It also stores the block's data in its own memory copy. Nodes send it read misses, write misses and write-backs. The home answers with data replies and sends invalidate, fetch and fetch-with-invalidate messages to the nodes that must give up or hand over their copy.

The controller works on one transaction at a time. An accepted request is latched, and `req_ready_o` stays low until the transaction has finished. When the current owner has to return the block, the controller waits for that data on a dedicated return channel. It writes the returned value into memory and then forwards it to the requester. When invalidates are needed, it sends them one per cycle, lowest node number first. The requester's data reply comes after the last invalidate.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is uncached with an empty sharer set and a memory value of zero; `req_ready_o` is high and `msg_valid_o` is low.
- R2: A read miss (kind 0) to an uncached block gives one data reply (message kind 0) carrying the memory value to the requester, and the block becomes shared with only the requester.
- R3: A write miss (kind 1) to an uncached block gives one data reply to the requester, and the block becomes exclusive with the requester as owner.
- R4: A read miss to a shared block gives a data reply from memory and adds the requester to the sharer set; existing sharers keep their copies.
- R5: A write miss to a shared block sends one invalidate (message kind 1) per cycle to every other sharer in ascending node order, never to the requester, then a data reply; the requester becomes the sole owner.
- R6: A read miss to an exclusive block sends a fetch (message kind 2) to the owner and waits for `fetch_valid_i`; the returned data is written to memory and replied to the requester; the block becomes shared by the old owner and the requester.
- R7: A write miss to an exclusive block sends a fetch-with-invalidate (message kind 3) to the owner, writes the returned data to memory, replies it to the requester, and makes the requester the only owner.
- R8: A write-back (kind 2) from the owner of an exclusive block writes its data to memory and leaves the block uncached with no sharers, sending no message.
- R9: A write-back from a node that is not the exclusive owner, and any request of kind 3, change neither memory nor directory and send no message.
- R10: From the cycle after acceptance until the transaction ends, `req_ready_o` is low, including the whole wait for owner data. Messages appear only in that window, and every message carries the request's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle and accepting a request |
| req_kind_i | input | 2 | 0 read miss, 1 write miss, 2 write-back, 3 reserved |
| req_node_i | input | NODE_W | Requesting node number |
| req_addr_i | input | ADDR_W | Block index |
| req_data_i | input | DATA_W | Write-back data |
| fetch_valid_i | input | 1 | Owner's data returned after fetch |
| fetch_data_i | input | DATA_W | Owner's returned data |
| msg_valid_o | output | 1 | Outgoing message valid this cycle |
| msg_kind_o | output | 2 | 0 data reply, 1 invalidate, 2 fetch, 3 fetch-with-invalidate |
| msg_node_o | output | NODE_W | Destination node |
| msg_addr_o | output | ADDR_W | Block index of the message |
| msg_data_o | output | DATA_W | Data of a data reply |

## Verification
A wrong directory state shows up only when a later request reaches the same block. A lost sharer bit drops an invalidate on the next write miss. A stale exclusive state turns a plain data reply into a fetch. A bad memory write returns a wrong value on the next data reply. The bench therefore packs many requests onto a few blocks, so that each corrupted entry is exposed within a few transactions. Every outgoing message is compared cycle by cycle with the sequence predicted by the bench's own model, so an invalidate in the wrong order or to the wrong node fails in the cycle it appears.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {DIR_UNC = 2'd0, DIR_SHR = 2'd1, DIR_EXC = 2'd2} dir_state_e;
  typedef enum logic [1:0] {REQ_RD = 2'd0, REQ_WR = 2'd1, REQ_WB = 2'd2, REQ_RSV = 2'd3} req_kind_e;
  typedef enum logic [1:0] {MSG_DATA = 2'd0, MSG_INV = 2'd1, MSG_FETCH = 2'd2, MSG_FINV = 2'd3} msg_kind_e;
  typedef enum logic [2:0] {ST_IDLE, ST_EXEC, ST_INV, ST_WAIT, ST_GRANT} ctl_state_e;
endpackage

// File: rtl/dir_lowest_pick.sv
module dir_lowest_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     mask_i,
  output logic [N-1:0]     onehot_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N-1:0] seen;
  assign seen[0] = 1'b0;

  for (genvar g = 0; g < N; g++) begin : g_bit
    assign onehot_o[g] = mask_i[g] & ~seen[g];
    if (g < N - 1) begin : g_chain
      assign seen[g+1] = seen[g] | mask_i[g];
    end
  end

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/dir_table.sv
module dir_table
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] idx_i,
  output dir_state_e        state_o,
  output logic [NODES-1:0]  sharers_o,
  input  logic              we_i,
  input  dir_state_e        state_i,
  input  logic [NODES-1:0]  sharers_i
);
  dir_state_e       st_q [BLOCKS];
  logic [NODES-1:0] sh_q [BLOCKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < BLOCKS; b++) begin
        st_q[b] <= DIR_UNC;
        sh_q[b] <= '0;
      end
    end else if (we_i) begin
      st_q[idx_i] <= state_i;
      sh_q[idx_i] <= sharers_i;
    end
  end

  assign state_o   = st_q[idx_i];
  assign sharers_o = sh_q[idx_i];
endmodule

// File: rtl/dir_data_mem.sv
module dir_data_mem #(
  parameter int BLOCKS = 8,
  parameter int ADDR_W = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] idx_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i
);
  logic [DATA_W-1:0] mem_q [BLOCKS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < BLOCKS; b++) mem_q[b] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int NODES  = 4,
  parameter int BLOCKS = 8,
  parameter int DATA_W = 16,
  localparam int NODE_W = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int ADDR_W = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_kind_i,
  input  logic [NODE_W-1:0] req_node_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic              fetch_valid_i,
  input  logic [DATA_W-1:0] fetch_data_i,
  output logic              msg_valid_o,
  output logic [1:0]        msg_kind_o,
  output logic [NODE_W-1:0] msg_node_o,
  output logic [ADDR_W-1:0] msg_addr_o,
  output logic [DATA_W-1:0] msg_data_o
);
  ctl_state_e        st_q, st_d;
  req_kind_e         kind_q;
  logic [NODE_W-1:0] node_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [NODES-1:0]  pend_q, pend_d;
  dir_state_e        gst_q, gst_d;
  logic [NODES-1:0]  gsh_q, gsh_d;

  dir_state_e        ent_state, tbl_state;
  logic [NODES-1:0]  ent_sh, tbl_sh;
  logic              tbl_we, mem_we;
  logic [DATA_W-1:0] mem_rd, mem_wd;

  logic [NODES-1:0]  req_bit, others, pick_mask, pick_oh, own_oh;
  logic [NODE_W-1:0] pick_idx, own_idx;
  msg_kind_e         mkind;
  logic              accept;

  dir_table #(.NODES(NODES), .BLOCKS(BLOCKS), .ADDR_W(ADDR_W)) u_table (
    .clk_i(clk_i), .rst_ni(rst_ni), .idx_i(addr_q),
    .state_o(ent_state), .sharers_o(ent_sh),
    .we_i(tbl_we), .state_i(tbl_state), .sharers_i(tbl_sh)
  );

  dir_data_mem #(.BLOCKS(BLOCKS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i(clk_i), .rst_ni(rst_ni), .idx_i(addr_q),
    .rdata_o(mem_rd), .we_i(mem_we), .wdata_i(mem_wd)
  );

  // next invalidate target (from pending set, or from the fresh sharer set in EXEC)
  dir_lowest_pick #(.N(NODES), .IDX_W(NODE_W)) u_pick_inv (
    .mask_i(pick_mask), .onehot_o(pick_oh), .idx_o(pick_idx)
  );

  // owner of an exclusive block is its single sharer bit
  dir_lowest_pick #(.N(NODES), .IDX_W(NODE_W)) u_pick_own (
    .mask_i(ent_sh), .onehot_o(own_oh), .idx_o(own_idx)
  );

  assign req_bit   = NODES'(1) << node_q;
  assign others    = ent_sh & ~req_bit;
  assign pick_mask = (st_q == ST_INV) ? pend_q : others;
  assign accept    = req_valid_i && req_ready_o;

  assign req_ready_o = (st_q == ST_IDLE);
  assign msg_kind_o  = mkind;
  assign msg_addr_o  = addr_q;
  assign msg_data_o  = mem_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      kind_q <= REQ_RD;
      node_q <= '0;
      addr_q <= '0;
      data_q <= '0;
      pend_q <= '0;
      gst_q  <= DIR_UNC;
      gsh_q  <= '0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      gst_q  <= gst_d;
      gsh_q  <= gsh_d;
      if (accept) begin
        kind_q <= req_kind_e'(req_kind_i);
        node_q <= req_node_i;
        addr_q <= req_addr_i;
        data_q <= req_data_i;
      end
    end
  end

  always_comb begin
    st_d        = st_q;
    pend_d      = pend_q;
    gst_d       = gst_q;
    gsh_d       = gsh_q;
    msg_valid_o = 1'b0;
    mkind       = MSG_DATA;
    msg_node_o  = node_q;
    tbl_we      = 1'b0;
    tbl_state   = ent_state;
    tbl_sh      = ent_sh;
    mem_we      = 1'b0;
    mem_wd      = data_q;

    unique case (st_q)
      ST_IDLE: begin
        if (accept) st_d = ST_EXEC;
      end

      ST_EXEC: begin
        st_d = ST_IDLE;
        unique case (kind_q)
          REQ_RD: begin
            if (ent_state == DIR_EXC) begin
              msg_valid_o = 1'b1;
              mkind       = MSG_FETCH;
              msg_node_o  = own_idx;
              gst_d       = DIR_SHR;
              gsh_d       = own_oh | req_bit;
              st_d        = ST_WAIT;
            end else begin
              msg_valid_o = 1'b1;
              tbl_we      = 1'b1;
              tbl_state   = DIR_SHR;
              tbl_sh      = (ent_state == DIR_SHR) ? (ent_sh | req_bit) : req_bit;
            end
          end
          REQ_WR: begin
            if (ent_state == DIR_EXC) begin
              msg_valid_o = 1'b1;
              mkind       = MSG_FINV;
              msg_node_o  = own_idx;
              gst_d       = DIR_EXC;
              gsh_d       = req_bit;
              st_d        = ST_WAIT;
            end else if (ent_state == DIR_SHR && others != '0) begin
              msg_valid_o = 1'b1;
              mkind       = MSG_INV;
              msg_node_o  = pick_idx;
              pend_d      = others & ~pick_oh;
              gst_d       = DIR_EXC;
              gsh_d       = req_bit;
              st_d        = ((others & ~pick_oh) == '0) ? ST_GRANT : ST_INV;
            end else begin
              msg_valid_o = 1'b1;
              tbl_we      = 1'b1;
              tbl_state   = DIR_EXC;
              tbl_sh      = req_bit;
            end
          end
          REQ_WB: begin
            if (ent_state == DIR_EXC && ent_sh[node_q]) begin
              mem_we    = 1'b1;
              mem_wd    = data_q;
              tbl_we    = 1'b1;
              tbl_state = DIR_UNC;
              tbl_sh    = '0;
            end
          end
          default: ;
        endcase
      end

      ST_INV: begin
        msg_valid_o = 1'b1;
        mkind       = MSG_INV;
        msg_node_o  = pick_idx;
        pend_d      = pend_q & ~pick_oh;
        if ((pend_q & ~pick_oh) == '0) st_d = ST_GRANT;
      end

      ST_WAIT: begin
        if (fetch_valid_i) begin
          mem_we = 1'b1;
          mem_wd = fetch_data_i;
          st_d   = ST_GRANT;
        end
      end

      ST_GRANT: begin
        msg_valid_o = 1'b1;
        tbl_we      = 1'b1;
        tbl_state   = gst_q;
        tbl_sh      = gsh_q;
        st_d        = ST_IDLE;
      end

      default: st_d = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk #(
  parameter int NODES  = 4,
  parameter int NODE_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              msg_valid_o,
  input logic [1:0]        msg_kind_o,
  input logic [NODE_W-1:0] msg_node_o,
  input logic [NODE_W-1:0] cur_node_i,
  input logic [1:0]        ent_state_i,
  input logic [NODES-1:0]  ent_sh_i
);
  assert_accept_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  assert_msg_only_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> !req_ready_o);

  assert_inv_skip_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_kind_o == 2'd1) |-> (msg_node_o != cur_node_i));

  assert_inv_ascending_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_kind_o == 2'd1 && $past(msg_valid_o && msg_kind_o == 2'd1))
      |-> (msg_node_o > $past(msg_node_o)));

  assert_fetch_then_wait_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_kind_o[1]) |=> !msg_valid_o);

  assert_excl_one_owner_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_state_i == 2'd2) |-> ($countones(ent_sh_i) == 1));

  assert_uncached_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ent_state_i == 2'd0) |-> (ent_sh_i == '0));
endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(.NODES(NODES), .NODE_W(NODE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .msg_valid_o(msg_valid_o), .msg_kind_o(msg_kind_o), .msg_node_o(msg_node_o),
  .cur_node_i(node_q), .ent_state_i(ent_state), .ent_sh_i(ent_sh)
);

// File: tb/sim_dir_home_ctrl.sv
`timescale 1ns/1ps
module sim_dir_home_ctrl;
  localparam int NODES = 4, BLOCKS = 8, DATA_W = 16, NODE_W = 2, ADDR_W = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_kind = '0;
  logic [NODE_W-1:0] req_node = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_data = '0;
  logic fetch_valid = 1'b0;
  logic [DATA_W-1:0] fetch_data = '0;
  logic msg_valid;
  logic [1:0] msg_kind;
  logic [NODE_W-1:0] msg_node;
  logic [ADDR_W-1:0] msg_addr;
  logic [DATA_W-1:0] msg_data;

  int checks = 0, fails = 0;

  // model: 0 uncached, 1 shared, 2 exclusive
  int               m_st [BLOCKS];
  logic [NODES-1:0] m_sh [BLOCKS];
  logic [DATA_W-1:0] m_mem [BLOCKS];

  int               e_n;
  int               e_kind [8];
  int               e_node [8];
  logic [DATA_W-1:0] e_data [8];

  always #5 clk = ~clk;

  dir_home_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_kind_i(req_kind), .req_node_i(req_node), .req_addr_i(req_addr), .req_data_i(req_data),
    .fetch_valid_i(fetch_valid), .fetch_data_i(fetch_data),
    .msg_valid_o(msg_valid), .msg_kind_o(msg_kind), .msg_node_o(msg_node),
    .msg_addr_o(msg_addr), .msg_data_o(msg_data)
  );

  function automatic int owner_of(logic [NODES-1:0] sh);
    for (int i = 0; i < NODES; i++) if (sh[i]) return i;
    return 0;
  endfunction

  function automatic void push(int k, int n, logic [DATA_W-1:0] d);
    e_kind[e_n] = k; e_node[e_n] = n; e_data[e_n] = d; e_n++;
  endfunction

  // expected messages and model update, from the requirements
  function automatic string predict(int kind, int node, int addr,
                                    logic [DATA_W-1:0] wd, logic [DATA_W-1:0] fd);
    logic [NODES-1:0] bit_r = NODES'(1) << node;
    e_n = 0;
    case (kind)
      0: begin
        if (m_st[addr] == 2) begin
          push(2, owner_of(m_sh[addr]), '0);
          m_mem[addr] = fd; push(0, node, fd);
          m_st[addr] = 1; m_sh[addr] = m_sh[addr] | bit_r; return "R6";
        end else if (m_st[addr] == 1) begin
          push(0, node, m_mem[addr]); m_sh[addr] = m_sh[addr] | bit_r; return "R4";
        end else begin
          push(0, node, m_mem[addr]); m_st[addr] = 1; m_sh[addr] = bit_r; return "R2";
        end
      end
      1: begin
        string t;
        if (m_st[addr] == 2) begin
          push(3, owner_of(m_sh[addr]), '0);
          m_mem[addr] = fd; push(0, node, fd); t = "R7";
        end else if (m_st[addr] == 1) begin
          for (int i = 0; i < NODES; i++) if (m_sh[addr][i] && i != node) push(1, i, '0);
          push(0, node, m_mem[addr]); t = "R5";
        end else begin
          push(0, node, m_mem[addr]); t = "R3";
        end
        m_st[addr] = 2; m_sh[addr] = bit_r; return t;
      end
      2: begin
        if (m_st[addr] == 2 && m_sh[addr][node]) begin
          m_mem[addr] = wd; m_st[addr] = 0; m_sh[addr] = '0; return "R8";
        end
        return "R9";
      end
      default: return "R9";
    endcase
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic run_req(int kind, int node, int addr, logic [DATA_W-1:0] wd, logic [DATA_W-1:0] fd);
    string tag;
    int got = 0, cd = -1, cyc = 0;
    bit done = 0, early = 0;
    tag = predict(kind, node, addr, wd, fd);
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind[1:0]; req_node = node[NODE_W-1:0];
    req_addr = addr[ADDR_W-1:0]; req_data = wd;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R10", "ready after accept", int'(req_ready), 0);
    while (!done && cyc < 100) begin
      if (msg_valid) begin
        if (got < e_n) begin
          check(msg_kind == e_kind[got][1:0] && msg_node == e_node[got][NODE_W-1:0],
                tag, "msg kind*10+node", msg_kind*10 + msg_node, e_kind[got]*10 + e_node[got]);
          check(msg_addr == addr[ADDR_W-1:0], "R10", "msg addr", msg_addr, addr);
          if (e_kind[got] == 0)
            check(msg_data == e_data[got], tag, "reply data", msg_data, e_data[got]);
        end else begin
          check(1'b0, tag, "extra message kind", msg_kind, -1);
        end
        if (msg_kind[1]) cd = 2;
        got++;
      end
      if (req_ready && got < e_n) early = 1;
      if (cd == 0) begin fetch_valid = 1'b1; fetch_data = fd; end
      else fetch_valid = 1'b0;
      if (cd >= 0) cd--;
      if (req_ready && !fetch_valid && cd < 0) done = 1;
      else begin @(negedge clk); cyc++; end
    end
    fetch_valid = 1'b0;
    check(!early, "R10", "ready high before transaction end", int'(early), 0);
    check(got == e_n, tag, "message count", got, e_n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'h1dc0);
    for (int b = 0; b < BLOCKS; b++) begin m_st[b] = 0; m_sh[b] = '0; m_mem[b] = '0; end
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready in reset", int'(req_ready), 1);
    check(msg_valid == 1'b0, "R1", "msg_valid in reset", int'(msg_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1 && msg_valid == 1'b0, "R1", "idle after reset", int'(req_ready), 1);

    // directed corner cases
    run_req(0, 2, 0, 16'h0, 16'h0);        // R1/R2 zero data
    run_req(0, 0, 0, 16'h0, 16'h0);        // R4
    run_req(0, 3, 0, 16'h0, 16'h0);        // R4
    run_req(1, 2, 0, 16'h0, 16'h0);        // R5 inv 0,3 skip 2
    run_req(0, 1, 0, 16'h0, 16'hA5A5);     // R6 fetch from 2
    run_req(1, 0, 0, 16'h0, 16'h0);        // R5 inv 1,2
    run_req(1, 3, 0, 16'h0, 16'h5A5A);     // R7
    run_req(2, 1, 0, 16'hDEAD, 16'h0);     // R9 non-owner
    run_req(0, 1, 0, 16'h0, 16'h1234);     // R9 observed: still exclusive, fetch
    run_req(1, 1, 5, 16'h0, 16'h0);        // R3
    run_req(2, 1, 5, 16'hBEEF, 16'h0);     // R8
    run_req(3, 2, 5, 16'h7777, 16'h0);     // R9 reserved
    run_req(2, 0, 5, 16'h1111, 16'h0);     // R9 uncached
    run_req(0, 2, 5, 16'h0, 16'h0);        // R8 data visible
    run_req(1, 2, 5, 16'h0, 16'h0);        // R5 sole sharer is requester
    run_req(1, 2, 5, 16'h0, 16'h4321);     // R7 owner == requester

    for (int n = 0; n < 600; n++) begin
      int k = $urandom_range(0, 9);
      int kind = (k < 4) ? 0 : (k < 7) ? 1 : (k < 9) ? 2 : 3;
      int node = $urandom_range(0, NODES - 1);
      int addr = $urandom_range(0, 3);
      logic [DATA_W-1:0] wd = DATA_W'($urandom);
      logic [DATA_W-1:0] fd = DATA_W'($urandom);
      if (kind == 2 && m_st[addr] == 2 && $urandom_range(0, 1) == 1) node = owner_of(m_sh[addr]);
      run_req(kind, node, addr, wd, fd);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule